// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Period-End Updates

This block generates four independent pulse-width modulated outputs under control of a small memory-mapped register file. Each channel divides the input clock by a power of two, runs a period counter against a programmed period length, and compares it with a programmed duty threshold. Every period begins at the inactive level and turns active once the counter reaches the duty threshold. A per-channel polarity bit swaps which level counts as active.

Software can change a running channel's duty or period without a glitch. It writes the new value into a per-channel holding register, and a mode bit chooses whether that value is destined for duty or for period. The channel copies the held value across only when its current period ends. Global write-one registers start and stop channels, a status register reports which channels run, and a flag register records each period start and clears itself when read.

The bus is a single-cycle valid/write strobe. Read data is registered and appears one cycle after the read strobe.

Top module: `pwm_quad`

## Requirements
- R1: After enable, the counter value k runs 0..period-1 at the channel tick rate. The channel is inactive while k < duty and active while duty <= k < period, so the first sample after enable is inactive unless duty is 0.
- R2: The channel tick rate is the input clock divided by 2^s, where s is mode register bits [3:0]. Values above 10 act as 10.
- R3: The output pin equals the active state XOR mode bit 9, so setting bit 9 inverts the pin. A disabled channel drives bit 9, which is its inactive level.
- R4: Writing the update register (channel offset 0x10) holds the value. At the next period end the held value is copied into duty if mode bit 10 is 0, or into period if bit 10 is 1. Until then, duty and period read back unchanged.
- R5: Channel n's registers sit at 0x200 + 0x20*n: mode at 0x00 (bits 10, 9, 3:0 stored), duty at 0x04 and period at 0x08 (16 bits each), and update at 0x10 (write-only, reads 0).
- R6: A write to 0x04 starts each channel whose data bit [n] is 1. A write to 0x08 stops each channel whose bit is 1. Zero bits change nothing. The status register at 0x0C reads the running channels in bits [3:0].
- R7: Flag bit n at 0x1C is set each time channel n wraps from period-1 back to 0. A read returns all flag bits and clears them together.
- R8: A flag set in the same cycle as a flag-register read is not returned by that read. It survives for the next read.
- R9: If duty >= period, the channel stays inactive for the whole period. If period is 0, the channel stays inactive and never sets its flag.
- R10: Stopping a channel resets its counter and drops any held update. A later start begins a fresh period at count 0.
- R11: After reset, all outputs and registers are 0. Reads of unmapped addresses, and of the enable and disable registers, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| pwm_out | output | 4 | Channel output pins |

## Verification
Two events can fall on the same clock edge: a channel's period wrap setting its flag, and a bus read clearing the flag register. The bench enables a single channel with a 20-cycle period at a known edge and counts cycles so that the flag read lands exactly on the wrap edge. That read must return zero and the following read must return the channel's bit. A third read checks the register is then clear. The same edge-counting approach times update-register writes against period ends, so the held value is seen unapplied before the wrap and applied after it.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 10;
    localparam int DIV_MAX = 10;
    localparam int STRIDE_LG = 5;

    localparam logic [ADDR_W-1:0] A_START  = 10'h004;
    localparam logic [ADDR_W-1:0] A_STOP   = 10'h008;
    localparam logic [ADDR_W-1:0] A_RUN    = 10'h00C;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 10'h01C;
    localparam logic [ADDR_W-1:0] A_CHBASE = 10'h200;

    localparam logic [STRIDE_LG-1:0] O_MODE = 5'h00;
    localparam logic [STRIDE_LG-1:0] O_DUTY = 5'h04;
    localparam logic [STRIDE_LG-1:0] O_PRD  = 5'h08;
    localparam logic [STRIDE_LG-1:0] O_HOLD = 5'h10;

    localparam int INV_BIT = 9;
    localparam int TGT_BIT = 10;

    typedef struct packed {
        logic       hold_to_prd;
        logic       invert;
        logic [3:0] div_sel;
    } mode_t;

    typedef enum logic [2:0] {
        F_NONE,
        F_MODE,
        F_DUTY,
        F_PRD,
        F_HOLD
    } ch_field_e;

    function automatic mode_t word_to_mode(logic [REG_W-1:0] w);
        mode_t m;
        m.div_sel     = w[3:0];
        m.invert      = w[INV_BIT];
        m.hold_to_prd = w[TGT_BIT];
        return m;
    endfunction

    function automatic logic [REG_W-1:0] mode_to_word(mode_t m);
        logic [REG_W-1:0] w;
        w          = '0;
        w[3:0]     = m.div_sel;
        w[INV_BIT] = m.invert;
        w[TGT_BIT] = m.hold_to_prd;
        return w;
    endfunction

    function automatic ch_field_e decode_field(logic [STRIDE_LG-1:0] off);
        case (off)
            O_MODE:  return F_MODE;
            O_DUTY:  return F_DUTY;
            O_PRD:   return F_PRD;
            O_HOLD:  return F_HOLD;
            default: return F_NONE;
        endcase
    endfunction

    function automatic logic [3:0] clamp_div(logic [3:0] s);
        return (s > 4'(DIV_MAX)) ? 4'(DIV_MAX) : s;
    endfunction

endpackage

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
    import pwm_quad_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               wr_en,
    input  ch_field_e          wr_field,
    input  logic [REG_W-1:0]   wdata,
    output mode_t              mode_o,
    output logic [CNT_W-1:0]   duty_o,
    output logic [CNT_W-1:0]   prd_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               wrap_o,
    output logic               pwm_o
);

    mode_t              mode_q;
    logic [CNT_W-1:0]   duty_q;
    logic [CNT_W-1:0]   prd_q;
    logic [CNT_W-1:0]   hold_q;
    logic               pend_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [DIV_MAX-1:0] pre_q;

    logic [DIV_MAX:0]   one_sh;
    logic [DIV_MAX-1:0] pre_lim;
    logic               tick;
    logic               prd_nz;
    logic               at_last;
    logic               wrap;
    logic               active;
    logic               unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        one_sh  = (DIV_MAX+1)'(1) << clamp_div(mode_q.div_sel);
        pre_lim = one_sh[DIV_MAX-1:0] - DIV_MAX'(1);
        tick    = en && (pre_q >= pre_lim);
        prd_nz  = (prd_q != '0);
        at_last = (cnt_q >= prd_q - CNT_W'(1));
        wrap    = tick && prd_nz && at_last;
        active  = en && prd_nz && (cnt_q >= duty_q) && (cnt_q < prd_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            duty_q <= '0;
            prd_q  <= '0;
            hold_q <= '0;
            pend_q <= 1'b0;
            cnt_q  <= '0;
            pre_q  <= '0;
        end else begin
            if (wrap && pend_q) begin
                if (mode_q.hold_to_prd) prd_q  <= hold_q;
                else                    duty_q <= hold_q;
                pend_q <= 1'b0;
            end
            if (wr_en) begin
                case (wr_field)
                    F_MODE: mode_q <= word_to_mode(wdata);
                    F_DUTY: duty_q <= wdata[CNT_W-1:0];
                    F_PRD:  prd_q  <= wdata[CNT_W-1:0];
                    F_HOLD: begin
                        hold_q <= wdata[CNT_W-1:0];
                        pend_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (!en) begin
                pre_q  <= '0;
                cnt_q  <= '0;
                pend_q <= 1'b0;
            end else if (tick) begin
                pre_q <= '0;
                cnt_q <= (wrap || !prd_nz) ? '0 : cnt_q + CNT_W'(1);
            end else begin
                pre_q <= pre_q + DIV_MAX'(1);
            end
        end
    end

    assign mode_o = mode_q;
    assign duty_o = duty_q;
    assign prd_o  = prd_q;
    assign cnt_o  = cnt_q;
    assign wrap_o = wrap;
    assign pwm_o  = active ^ mode_q.invert;

endmodule

// File: rtl/pwm_quad_ctl.sv
module pwm_quad_ctl #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_wr,
    input  logic           stop_wr,
    input  logic           flags_rd,
    input  logic [NCH-1:0] mask,
    input  logic [NCH-1:0] wrap,
    output logic [NCH-1:0] run_o,
    output logic [NCH-1:0] flag_o
);

    logic [NCH-1:0] run_q;
    logic [NCH-1:0] flag_q;
    logic [NCH-1:0] set_m;
    logic [NCH-1:0] clr_m;

    always_comb begin
        set_m = start_wr ? mask : '0;
        clr_m = stop_wr  ? mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            run_q  <= (run_q | set_m) & ~clr_m;
            flag_q <= (flags_rd ? '0 : flag_q) | wrap;
        end
    end

    assign run_o  = run_q;
    assign flag_o = flag_q;

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int CIW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [ADDR_W-1:0] CH_END = A_CHBASE + ADDR_W'(NUM_CH << STRIDE_LG);

    logic                wr_acc;
    logic                rd_acc;
    logic                in_ch;
    logic [ADDR_W-1:0]   rel;
    logic [CIW-1:0]      ch_idx;
    ch_field_e           field;

    mode_t               mode_v [NUM_CH];
    logic [CNT_W-1:0]    duty_v [NUM_CH];
    logic [CNT_W-1:0]    prd_v  [NUM_CH];
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_v;
    logic [NUM_CH-1:0]   wrap_v;
    logic [NUM_CH-1:0]   en_q;
    logic [NUM_CH-1:0]   flag_q;
    logic [NUM_CH-1:0]   inv_v;
    logic [NUM_CH-1:0]   prd_zero;

    logic [REG_W-1:0]    rd_word;
    logic [REG_W-1:0]    rdata_q;

    always_comb begin
        wr_acc = bus_valid && bus_we;
        rd_acc = bus_valid && !bus_we;
        in_ch  = (bus_addr >= A_CHBASE) && (bus_addr < CH_END);
        rel    = bus_addr - A_CHBASE;
        ch_idx = rel[STRIDE_LG +: CIW];
        field  = in_ch ? decode_field(rel[STRIDE_LG-1:0]) : F_NONE;
    end

    pwm_quad_ctl #(.NCH(NUM_CH)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .start_wr (wr_acc && (bus_addr == A_START)),
        .stop_wr  (wr_acc && (bus_addr == A_STOP)),
        .flags_rd (rd_acc && (bus_addr == A_FLAGS)),
        .mask     (bus_wdata[NUM_CH-1:0]),
        .wrap     (wrap_v),
        .run_o    (en_q),
        .flag_o   (flag_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_quad_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .en       (en_q[i]),
            .wr_en    (wr_acc && in_ch && (ch_idx == CIW'(i))),
            .wr_field (field),
            .wdata    (bus_wdata),
            .mode_o   (mode_v[i]),
            .duty_o   (duty_v[i]),
            .prd_o    (prd_v[i]),
            .cnt_o    (cnt_v[i]),
            .wrap_o   (wrap_v[i]),
            .pwm_o    (pwm_out[i])
        );
        assign inv_v[i]    = mode_v[i].invert;
        assign prd_zero[i] = (prd_v[i] == '0);
    end

    always_comb begin
        rd_word = '0;
        if (in_ch) begin
            case (field)
                F_MODE:  rd_word = mode_to_word(mode_v[ch_idx]);
                F_DUTY:  rd_word = REG_W'(duty_v[ch_idx]);
                F_PRD:   rd_word = REG_W'(prd_v[ch_idx]);
                default: rd_word = '0;
            endcase
        end else if (bus_addr == A_RUN) begin
            rd_word = REG_W'(en_q);
        end else if (bus_addr == A_FLAGS) begin
            rd_word = REG_W'(flag_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (rd_acc) rdata_q <= rd_word;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
    import pwm_quad_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_valid,
    input logic                     bus_we,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [REG_W-1:0]         bus_wdata,
    input logic [REG_W-1:0]         bus_rdata,
    input logic [NCH-1:0]           pwm_out,
    input logic [NCH-1:0]           en_q,
    input logic [NCH-1:0]           flag_q,
    input logic [NCH-1:0]           inv_v,
    input logic [NCH-1:0]           prd_zero,
    input logic [NCH-1:0][CNT_W-1:0] cnt_v
);

    // R6
    start_sets_run_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_we && bus_addr == A_START)
        |=> ((en_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

    // R6
    stop_clears_run_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_we && bus_addr == A_STOP)
        |=> ((en_q & $past(bus_wdata[NCH-1:0])) == '0));

    // R7
    flag_read_data_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_we && bus_addr == A_FLAGS)
        |=> (bus_rdata == REG_W'($past(flag_q))));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R3
        idle_level_chk: assert property (@(posedge clk) disable iff (rst)
            !en_q[i] |-> (pwm_out[i] == inv_v[i]));

        // R8
        flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (flag_q[i] && !(bus_valid && !bus_we && bus_addr == A_FLAGS))
            |=> flag_q[i]);

        // R9
        zero_prd_flag_chk: assert property (@(posedge clk) disable iff (rst)
            (prd_zero[i] && $stable(prd_zero[i]) && !flag_q[i]
             && !(bus_valid && bus_we))
            |=> !flag_q[i]);

        // R10
        idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
            !en_q[i] |=> (cnt_v[i] == '0));
    end

endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .en_q      (en_q),
    .flag_q    (flag_q),
    .inv_v     (inv_v),
    .prd_zero  (prd_zero),
    .cnt_v     (cnt_v)
);

// File: tb/tb_pwm_quad.sv
module tb_pwm_quad;
    import pwm_quad_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pwm_quad dut (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // {ch[38:37], div[36:33], inv[32], period[31:16], duty[15:0]}
    localparam logic [38:0] VEC [8] = '{
        {2'd0, 4'd0,  1'b0, 16'd10, 16'd3},
        {2'd1, 4'd1,  1'b0, 16'd8,  16'd2},
        {2'd2, 4'd0,  1'b1, 16'd6,  16'd1},
        {2'd3, 4'd2,  1'b0, 16'd5,  16'd4},
        {2'd0, 4'd0,  1'b0, 16'd7,  16'd0},
        {2'd1, 4'd0,  1'b0, 16'd6,  16'd6},
        {2'd2, 4'd0,  1'b0, 16'd5,  16'd9},
        {2'd3, 4'd10, 1'b0, 16'd3,  16'd1}
    };

    function automatic logic [9:0] cha(int ch, logic [4:0] off);
        return 10'h200 + 10'(ch * 32) + 10'(off);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check("R11 reset pwm_out", 32'(pwm_out), 32'h0);
        rd(A_RUN, d);      check("R11 reset status", d, 32'h0);
        rd(cha(1, O_PRD), d); check("R11 reset period", d, 32'h0);
        rd(10'h100, d);    check("R11 unmapped 0x100", d, 32'h0);
        rd(10'h3FC, d);    check("R11 unmapped 0x3FC", d, 32'h0);

        // R5 register map readback
        wr(cha(2, O_DUTY), 32'h0000_1234);
        wr(cha(2, O_PRD),  32'hABCD_5678);
        wr(cha(2, O_MODE), 32'h0000_0603);
        wr(cha(2, O_HOLD), 32'h0000_0077);
        rd(cha(2, O_DUTY), d); check("R5 duty readback", d, 32'h1234);
        rd(cha(2, O_PRD),  d); check("R5 period readback", d, 32'h5678);
        rd(cha(2, O_MODE), d); check("R5 mode readback", d, 32'h0603);
        rd(cha(2, O_HOLD), d); check("R5 update reads zero", d, 32'h0);
        rd(cha(1, O_DUTY), d); check("R5 other channel untouched", d, 32'h0);

        // R6 start/stop write-one semantics
        wr(A_START, 32'h5); rd(A_RUN, d); check("R6 start 0101", d, 32'h5);
        wr(A_START, 32'h0); rd(A_RUN, d); check("R6 start zero no effect", d, 32'h5);
        wr(A_STOP,  32'h4); rd(A_RUN, d); check("R6 stop bit2", d, 32'h1);
        wr(A_STOP,  32'h0); rd(A_RUN, d); check("R6 stop zero no effect", d, 32'h1);
        rd(A_START, d); check("R11 start reg reads zero", d, 32'h0);

        // R3 disabled channel drives inverted inactive level
        wr(cha(3, 5'h0), 32'h0000_0200);
        check("R3 idle level inverted", 32'(pwm_out[3]), 32'h1);
        wr(cha(3, 5'h0), 32'h0);
        check("R3 idle level normal", 32'(pwm_out[3]), 32'h0);

        // R1 R2 R3 R9 vector table
        for (int v = 0; v < 8; v++) begin
            int ch, dv, p, du, win, hi, act;
            logic inv;
            ch  = int'(VEC[v][38:37]);
            dv  = int'(VEC[v][36:33]);
            inv = VEC[v][32];
            p   = int'(VEC[v][31:16]);
            du  = int'(VEC[v][15:0]);
            win = (2 * p) << dv;
            hi  = (du < p) ? ((2 * (p - du)) << dv) : 0;
            wr(A_STOP, 32'hF);
            wr(cha(ch, O_MODE), (32'(inv) << 9) | 32'(dv));
            wr(cha(ch, O_DUTY), 32'(du));
            wr(cha(ch, O_PRD),  32'(p));
            wr(A_START, 32'(1 << ch));
            check($sformatf("R1 vec%0d first sample inactive", v),
                  32'(pwm_out[ch] ^ inv), (du == 0) ? 32'h1 : 32'h0);
            act = 0;
            for (int k = 0; k < win; k++) begin
                if (k > 0) @(negedge clk);
                if (pwm_out[ch] != inv) act++;
            end
            check($sformatf("R1/R2/R3/R9 vec%0d active count", v), 32'(act), 32'(hi));
        end

        // R4 update register, duty target
        wr(A_STOP, 32'hF);
        wr(cha(0, O_MODE), 32'h0);
        wr(cha(0, O_DUTY), 32'd10);
        wr(cha(0, O_PRD),  32'd40);
        wr(A_START, 32'h1);
        wr(cha(0, O_HOLD), 32'd30);
        rd(cha(0, O_DUTY), d); check("R4 duty held before period end", d, 32'd10);
        repeat (50) @(negedge clk);
        rd(cha(0, O_DUTY), d); check("R4 duty applied after period end", d, 32'd30);
        // R4 update register, period target
        wr(cha(0, O_MODE), 32'h0000_0400);
        wr(cha(0, O_HOLD), 32'd60);
        rd(cha(0, O_PRD), d); check("R4 period held before period end", d, 32'd40);
        repeat (50) @(negedge clk);
        rd(cha(0, O_PRD), d); check("R4 period applied after period end", d, 32'd60);
        rd(cha(0, O_DUTY), d); check("R4 duty untouched by period update", d, 32'd30);

        // R10 stop drops held update, restart is fresh
        wr(A_STOP, 32'hF);
        wr(cha(0, O_MODE), 32'h0);
        wr(cha(0, O_DUTY), 32'd5);
        wr(cha(0, O_PRD),  32'd40);
        wr(A_START, 32'h1);
        wr(cha(0, O_HOLD), 32'd20);
        wr(A_STOP, 32'h1);
        wr(A_START, 32'h1);
        check("R10 restart begins inactive", 32'(pwm_out[0]), 32'h0);
        repeat (60) @(negedge clk);
        rd(cha(0, O_DUTY), d); check("R10 held update dropped", d, 32'd5);

        // R7 R8 flag set on the read edge
        wr(A_STOP, 32'hF);
        rd(A_FLAGS, d);
        wr(cha(1, O_MODE), 32'h0);
        wr(cha(1, O_DUTY), 32'd5);
        wr(cha(1, O_PRD),  32'd20);
        wr(A_START, 32'h2);
        repeat (18) @(negedge clk);
        rd(A_FLAGS, d); check("R8 read on wrap edge returns old", d, 32'h0);
        rd(A_FLAGS, d); check("R8 colliding flag kept", d, 32'h2);
        rd(A_FLAGS, d); check("R7 flags cleared by read", d, 32'h0);

        // R9 zero period
        wr(A_STOP, 32'hF);
        rd(A_FLAGS, d);
        wr(cha(2, O_MODE), 32'h0);
        wr(cha(2, O_DUTY), 32'h0);
        wr(cha(2, O_PRD),  32'h0);
        wr(A_START, 32'h4);
        repeat (60) @(negedge clk);
        check("R9 zero period inactive", 32'(pwm_out[2]), 32'h0);
        rd(A_FLAGS, d); check("R9 zero period no flag", d, 32'h0);

        finish_run();
    end

endmodule